// File: doc/BRIEF.md
# UART DMA Request Mode Controller

This block sits between a UART's character path and a DMA engine. It holds two small transmit and receive FIFOs. It decides, from software-written control registers, which DMA request lines may be active. From FIFO occupancy it raises a transmit request when the TX buffer has room to take a burst. It raises a receive request when the RX buffer holds enough characters to be worth a transfer.

The effective mode comes from one of two sources. A selector bit in a supplementary register either leaves the decision to a single legacy enable bit or hands it to a two-bit extended field. The extended field can choose no DMA, both directions, receive only or transmit only. Two self-clearing bits in the FIFO control register flush the FIFOs, reset their pointers and withdraw any pending request. A receiver-off bit in an auxiliary register stops serial data from entering the RX FIFO.

Top module: `uart_dma_ctl`

## Requirements
- R1: With the selector at 0, `dma_mode` is 01 when the legacy bit is 1 and 00 when it is 0, whatever the extended field holds.
- R2: With the selector at 1, `dma_mode` equals the extended field (00 none, 01 both directions, 10 RX only, 11 TX only), and writing the legacy bit has no effect on it.
- R3: Register map: address 0 is FIFO control (bit 1 RX clear, bit 2 TX clear, bit 3 legacy enable). Address 1 is supplementary (bit 0 selector, bits 2:1 extended field). Address 2 is auxiliary (bit 5 receiver off). A write to one address leaves the others unchanged.
- R4: Writing 1 to both clear bits empties both FIFOs on the clock edge after the write. The bits then drop by themselves, so data pushed afterwards is kept.
- R5: A flush drives the request of each flushed FIFO low on the flush edge. A request comes back only when its level condition holds again.
- R6: `dma_rx_req` is high one cycle after `rx_level >= RX_TRIG` in modes 01 and 10, and low otherwise.
- R7: `dma_tx_req` is high one cycle after `DEPTH - tx_level >= TX_TRIG` in modes 01 and 11, and low otherwise.
- R8: `dma_tx_ack` pushes `dma_tx_wdata`, and a push into a full FIFO is dropped. `dma_rx_ack` pops the head shown on `dma_rx_rdata`, and a pop of an empty FIFO does nothing. Both FIFOs keep arrival order.
- R9: While the receiver-off bit is 1, `ser_rx_valid` adds nothing to the RX FIFO.
- R10: A flush in the same cycle as a push or a pop leaves both levels at 0.
- R11: After reset both levels are 0, both requests are low and `dma_mode` is 00.
- R12: `ser_tx_valid` is high exactly when the TX FIFO is non-empty. `ser_tx_ready` consumes characters in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| dma_tx_ack | input | 1 | DMA write of one TX character |
| dma_tx_wdata | input | DATA_W | TX character from DMA |
| dma_rx_ack | input | 1 | DMA read of one RX character |
| dma_rx_rdata | output | DATA_W | RX FIFO head |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |
| ser_rx_valid | input | 1 | Receiver delivers a character |
| ser_rx_data | input | DATA_W | Received character |
| ser_tx_ready | input | 1 | Transmitter takes a character |
| ser_tx_valid | output | 1 | TX FIFO holds a character |
| ser_tx_data | output | DATA_W | TX FIFO head |
| dma_mode | output | 2 | Effective DMA mode |
| tx_level | output | $clog2(DEPTH+1) | TX FIFO fill level |
| rx_level | output | $clog2(DEPTH+1) | RX FIFO fill level |

## Verification
Some properties are checked on every cycle. Requests stay low after a cycle in mode none, and each request stays off in the mode that excludes its direction. A flush drops the request and zeroes the level. The RX level cannot grow while the receiver is off, and levels never exceed the depth. The bench scenarios cover the rest. They sweep the mode decode over every selector, legacy and field combination, and fill each FIFO level by level to test the trigger thresholds. They also check FIFO ordering, full and empty edges, and the return of the requests after a flush.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_BOTH = 2'b01,
    MODE_RX   = 2'b10,
    MODE_TX   = 2'b11
  } dma_mode_e;

  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_FIFO_CTL = 2'd0;
  localparam logic [1:0] ADDR_SUPP     = 2'd1;
  localparam logic [1:0] ADDR_AUX      = 2'd2;

  localparam int FC_RX_CLR  = 1;
  localparam int FC_TX_CLR  = 2;
  localparam int FC_LEGACY  = 3;
  localparam int SP_SEL     = 0;
  localparam int SP_EXT_LO  = 1;
  localparam int AUX_RX_OFF = 5;

endpackage

// File: rtl/uart_dma_regs.sv
module uart_dma_regs
  import uart_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output dma_mode_e        mode,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             rx_block
);

  logic       legacy_q, legacy_d;
  logic       sel_q, sel_d;
  logic [1:0] ext_q, ext_d;
  logic       rxoff_q, rxoff_d;
  logic       clr_tx_q, clr_tx_d;
  logic       clr_rx_q, clr_rx_d;
  logic       wr_fc, wr_sp, wr_aux;
  logic       unused_wdata;

  assign wr_fc  = wr_en && (addr == ADDR_FIFO_CTL);
  assign wr_sp  = wr_en && (addr == ADDR_SUPP);
  assign wr_aux = wr_en && (addr == ADDR_AUX);
  assign unused_wdata = ^{wdata[7:6], wdata[4]};

  // Next state: held values change only under their write enable.
  always_comb begin
    legacy_d = legacy_q;
    sel_d    = sel_q;
    ext_d    = ext_q;
    rxoff_d  = rxoff_q;
    clr_tx_d = wr_fc & wdata[FC_TX_CLR];
    clr_rx_d = wr_fc & wdata[FC_RX_CLR];
    if (wr_fc) legacy_d = wdata[FC_LEGACY];
    if (wr_sp) begin
      sel_d = wdata[SP_SEL];
      ext_d = wdata[SP_EXT_LO +: 2];
    end
    if (wr_aux) rxoff_d = wdata[AUX_RX_OFF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      sel_q    <= 1'b0;
      ext_q    <= 2'b00;
      rxoff_q  <= 1'b0;
      clr_tx_q <= 1'b0;
      clr_rx_q <= 1'b0;
    end else begin
      legacy_q <= legacy_d;
      sel_q    <= sel_d;
      ext_q    <= ext_d;
      rxoff_q  <= rxoff_d;
      clr_tx_q <= clr_tx_d;
      clr_rx_q <= clr_rx_d;
    end
  end

  // Mode decode from registered state only; the selector overrides the legacy bit.
  always_comb begin
    if (sel_q) mode = dma_mode_e'(ext_q);
    else       mode = legacy_q ? MODE_BOTH : MODE_NONE;
  end

  assign tx_flush = clr_tx_q;
  assign rx_flush = clr_rx_q;
  assign rx_block = rxoff_q;

endmodule

// File: rtl/uart_dma_fifo.sv
module uart_dma_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level
);

  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign do_push = push && (cnt_q != FULL_L) && !flush;
  assign do_pop  = pop  && (cnt_q != '0)     && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST_P) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST_P) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign level = cnt_q;

endmodule

// File: rtl/uart_dma_reqgen.sv
module uart_dma_reqgen
  import uart_dma_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RX_TRIG = 4,
  parameter int TX_TRIG = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dma_mode_e        mode,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_flush,
  input  logic             rx_flush,
  output logic             tx_req,
  output logic             rx_req
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] RXT_L   = LVL_W'(RX_TRIG);
  localparam logic [LVL_W-1:0] TXT_L   = LVL_W'(TX_TRIG);

  logic             tx_en, rx_en;
  logic             tx_req_q, tx_req_d, rx_req_q, rx_req_d;
  logic [LVL_W-1:0] tx_space;

  assign tx_en    = (mode == MODE_BOTH) || (mode == MODE_TX);
  assign rx_en    = (mode == MODE_BOTH) || (mode == MODE_RX);
  assign tx_space = DEPTH_L - tx_level;

  always_comb begin
    tx_req_d = !tx_flush && tx_en && (tx_space >= TXT_L);
    rx_req_d = !rx_flush && rx_en && (rx_level >= RXT_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req_q <= 1'b0;
      rx_req_q <= 1'b0;
    end else begin
      tx_req_q <= tx_req_d;
      rx_req_q <= rx_req_d;
    end
  end

  assign tx_req = tx_req_q;
  assign rx_req = rx_req_q;

endmodule

// File: rtl/uart_dma_ctl.sv
module uart_dma_ctl
  import uart_dma_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int RX_TRIG = 4,
  parameter int TX_TRIG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [1:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  input  logic                       dma_tx_ack,
  input  logic [DATA_W-1:0]          dma_tx_wdata,
  input  logic                       dma_rx_ack,
  output logic [DATA_W-1:0]          dma_rx_rdata,
  output logic                       dma_tx_req,
  output logic                       dma_rx_req,
  input  logic                       ser_rx_valid,
  input  logic [DATA_W-1:0]          ser_rx_data,
  input  logic                       ser_tx_ready,
  output logic                       ser_tx_valid,
  output logic [DATA_W-1:0]          ser_tx_data,
  output logic [1:0]                 dma_mode,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  dma_mode_e mode;
  logic      tx_flush, rx_flush, rx_block;
  logic      rx_push, tx_pop;

  uart_dma_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .mode     (mode),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .rx_block (rx_block)
  );

  assign rx_push      = ser_rx_valid && !rx_block;
  assign ser_tx_valid = (tx_level != '0);
  assign tx_pop       = ser_tx_ready && ser_tx_valid;

  uart_dma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (dma_tx_ack),
    .wdata (dma_tx_wdata),
    .pop   (tx_pop),
    .rdata (ser_tx_data),
    .level (tx_level)
  );

  uart_dma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (rx_push),
    .wdata (ser_rx_data),
    .pop   (dma_rx_ack),
    .rdata (dma_rx_rdata),
    .level (rx_level)
  );

  uart_dma_reqgen #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG), .TX_TRIG(TX_TRIG)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .tx_req   (dma_tx_req),
    .rx_req   (dma_rx_req)
  );

  assign dma_mode = mode;

endmodule

// File: rtl/uart_dma_ctl_chk.sv
module uart_dma_ctl_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       dma_mode,
  input logic             tx_req,
  input logic             rx_req,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic             rx_block,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level
);

  assert_none_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode == 2'b00) |=> (!tx_req && !rx_req));

  assert_txonly_no_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode == 2'b11) |=> !rx_req);

  assert_rxonly_no_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode == 2'b10) |=> !tx_req);

  assert_tx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (!tx_req && tx_level == '0));

  assert_rx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (!rx_req && rx_level == '0));

  assert_rx_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_block && !rx_flush) |=> (rx_level <= $past(rx_level)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

endmodule

bind uart_dma_ctl uart_dma_ctl_chk #(.DEPTH(DEPTH), .LVL_W($clog2(DEPTH+1))) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dma_mode (dma_mode),
  .tx_req   (dma_tx_req),
  .rx_req   (dma_rx_req),
  .tx_flush (tx_flush),
  .rx_flush (rx_flush),
  .rx_block (rx_block),
  .tx_level (tx_level),
  .rx_level (rx_level)
);

// File: tb/uart_dma_ctl_test.sv
module uart_dma_ctl_test;

  localparam int DATA_W  = 8;
  localparam int DEPTH   = 8;
  localparam int RX_TRIG = 4;
  localparam int TX_TRIG = 4;
  localparam int LVL_W   = $clog2(DEPTH + 1);

  logic              clk, rst_n;
  logic              reg_wr_en;
  logic [1:0]        reg_addr;
  logic [7:0]        reg_wdata;
  logic              dma_tx_ack, dma_rx_ack;
  logic [DATA_W-1:0] dma_tx_wdata, dma_rx_rdata;
  logic              dma_tx_req, dma_rx_req;
  logic              ser_rx_valid, ser_tx_ready, ser_tx_valid;
  logic [DATA_W-1:0] ser_rx_data, ser_tx_data;
  logic [1:0]        dma_mode;
  logic [LVL_W-1:0]  tx_level, rx_level;

  int checks = 0;
  int fails  = 0;

  uart_dma_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RX_TRIG(RX_TRIG), .TX_TRIG(TX_TRIG)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dma_tx_ack(dma_tx_ack), .dma_tx_wdata(dma_tx_wdata),
    .dma_rx_ack(dma_rx_ack), .dma_rx_rdata(dma_rx_rdata), .dma_tx_req(dma_tx_req),
    .dma_rx_req(dma_rx_req), .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data),
    .ser_tx_ready(ser_tx_ready), .ser_tx_valid(ser_tx_valid), .ser_tx_data(ser_tx_data),
    .dma_mode(dma_mode), .tx_level(tx_level), .rx_level(rx_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic flush_all(input bit leg);
    wr(2'd0, leg ? 8'h0E : 8'h06);
    step();
  endtask

  task automatic tx_push(input logic [7:0] d);
    dma_tx_ack = 1'b1; dma_tx_wdata = d;
    step();
    dma_tx_ack = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] d);
    ser_rx_valid = 1'b1; ser_rx_data = d;
    step();
    ser_rx_valid = 1'b0;
  endtask

  function automatic int exp_mode(input int sel, input int leg, input int ext);
    if (sel != 0) return ext;
    return (leg != 0) ? 1 : 0;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    dma_tx_ack = 1'b0; dma_tx_wdata = '0; dma_rx_ack = 1'b0;
    ser_rx_valid = 1'b0; ser_rx_data = '0; ser_tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk("R11 tx_level", int'(tx_level), 0);
    chk("R11 rx_level", int'(rx_level), 0);
    chk("R11 reqs", int'({dma_tx_req, dma_rx_req}), 0);
    chk("R11 mode", int'(dma_mode), 0);

    // R1/R2: full decode sweep
    for (int sel = 0; sel < 2; sel++)
      for (int leg = 0; leg < 2; leg++)
        for (int ext = 0; ext < 4; ext++) begin
          wr(2'd0, 8'(leg << 3));
          wr(2'd1, 8'((ext << 1) | sel));
          chk(sel ? "R2 decode" : "R1 decode", int'(dma_mode), exp_mode(sel, leg, ext));
        end

    // R6/R7: threshold sweeps in every mode, mode 4 = legacy path
    for (int m = 0; m < 5; m++) begin
      int em;
      em = (m < 4) ? m : 1;
      if (m < 4) begin
        wr(2'd0, 8'h00);
        wr(2'd1, 8'((m << 1) | 1));
      end else begin
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h08);
      end
      flush_all(m == 4);
      for (int k = 0; k <= DEPTH; k++) begin
        step();
        chk("R7 tx_req", int'(dma_tx_req),
            int'((em == 1 || em == 3) && (DEPTH - k) >= TX_TRIG));
        if (k < DEPTH) tx_push(8'(k));
      end
      for (int k = 0; k <= DEPTH; k++) begin
        step();
        chk("R6 rx_req", int'(dma_rx_req),
            int'((em == 1 || em == 2) && k >= RX_TRIG));
        if (k < DEPTH) rx_in(8'(k));
      end
    end

    // R5: flush withdraws requests; legacy mode both, both FIFOs full
    chk("R5 rx_req before", int'(dma_rx_req), 1);
    wr(2'd0, 8'h0E);
    chk("R4 not yet flushed", int'(tx_level), DEPTH);
    step();
    chk("R5 rx_req at flush", int'(dma_rx_req), 0);
    chk("R5 tx_req at flush", int'(dma_tx_req), 0);
    chk("R4 tx_level", int'(tx_level), 0);
    chk("R4 rx_level", int'(rx_level), 0);
    step();
    chk("R5 tx_req returns", int'(dma_tx_req), 1);
    chk("R5 rx_req stays low", int'(dma_rx_req), 0);

    // R4: clear bits drop by themselves
    for (int i = 0; i < 3; i++) tx_push(8'(i));
    step();
    chk("R4 self clear", int'(tx_level), 3);

    // R10: flush coinciding with push and pop
    rx_in(8'h11); rx_in(8'h22);
    wr(2'd0, 8'h0E);
    dma_tx_ack = 1'b1; ser_rx_valid = 1'b1; dma_rx_ack = 1'b1;
    step();
    dma_tx_ack = 1'b0; ser_rx_valid = 1'b0; dma_rx_ack = 1'b0;
    chk("R10 tx_level", int'(tx_level), 0);
    chk("R10 rx_level", int'(rx_level), 0);

    // R8: empty pop, full push, ordering
    dma_rx_ack = 1'b1; step(); dma_rx_ack = 1'b0;
    chk("R8 empty pop", int'(rx_level), 0);
    for (int i = 0; i < DEPTH + 2; i++) tx_push(8'(i));
    chk("R8 full push", int'(tx_level), DEPTH);
    for (int i = 0; i < 5; i++) rx_in(8'(8'hA0 + i));
    for (int i = 0; i < 5; i++) begin
      chk("R8 rx order", int'(dma_rx_rdata), 8'hA0 + i);
      dma_rx_ack = 1'b1; step(); dma_rx_ack = 1'b0;
    end
    chk("R8 rx drained", int'(rx_level), 0);

    // R12: serial transmit side
    flush_all(1'b1);
    chk("R12 idle valid", int'(ser_tx_valid), 0);
    for (int i = 0; i < 4; i++) tx_push(8'(8'h30 + i));
    for (int i = 0; i < 4; i++) begin
      chk("R12 valid", int'(ser_tx_valid), 1);
      chk("R12 order", int'(ser_tx_data), 8'h30 + i);
      ser_tx_ready = 1'b1; step(); ser_tx_ready = 1'b0;
    end
    chk("R12 drained", int'(ser_tx_valid), 0);

    // R9: receiver off
    wr(2'd2, 8'h20);
    for (int i = 0; i < 3; i++) rx_in(8'h55);
    chk("R9 blocked", int'(rx_level), 0);
    wr(2'd2, 8'h00);
    rx_in(8'h66);
    chk("R9 unblocked", int'(rx_level), 1);

    // R2: legacy bit ignored under the selector; R1 on return
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h08);
    chk("R2 legacy set", int'(dma_mode), 1);
    wr(2'd0, 8'h00);
    chk("R2 legacy cleared", int'(dma_mode), 1);
    // R3: aux write leaves supplementary register alone
    wr(2'd2, 8'h07);
    chk("R3 aux isolated", int'(dma_mode), 1);
    wr(2'd1, 8'h02);
    chk("R1 selector off", int'(dma_mode), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule